// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block monitors a small group of general-purpose inputs (four by default) and raises edge interrupts on a single parent line. Every input has two pending flags, one for rising transitions and one for falling transitions. Both flags record events all the time, whatever the trigger setting. A 2-bit trigger field per input only picks which of the two flags shows up in the status register. The parent interrupt line is the OR of all visible status bits.

Software uses a simple synchronous register port with three locations. It reads the synchronized input levels, reads or writes the packed trigger fields, and reads the status. To acknowledge, it writes the status value back: a 1 in bit n clears both pending flags of input n. Before edge detection, each input passes through a two-stage synchronizer.

Top module: `gpio_edge_irq`

## Requirements
- R1: A synchronous active-high reset clears all pending flags and all trigger fields, and holds the interrupt line low.
- R2: Address 0 reads the synchronized input levels in bits [NUM_IN-1:0]. A change at an input shows up there two clock edges after it is applied. Writes to address 0 have no effect.
- R3: A 0-to-1 change of the synchronized level sets the rising flag of that input on the next edge. A 1-to-0 change sets the falling flag. Both flags are set whatever the trigger field holds, and each stays set until it is acknowledged.
- R4: Address 1 holds the trigger fields and can be read and written. The field for input n is at bits [2n+1:2n]. Code 0 selects nothing, code 1 selects the falling flag and code 2 selects the rising flag.
- R5: Trigger code 3 is not a both-edges mode. Status bit n reads 0 whatever the two flags hold.
- R6: Address 2 reads the status, where bit n is the flag selected by field n. The interrupt line is high exactly when any status bit is 1.
- R7: Writing a 1 to bit n of address 2 clears both flags of input n, whatever trigger is selected. A 0 bit leaves the flags of its input unchanged.
- R8: If an edge event meets an acknowledge of the same input in the same cycle, the event wins and its flag stays set.
- R9: A trigger write takes effect from the next cycle. A flag that was latched earlier while hidden appears in the status at once if its type is then selected.
- R10: Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpioIn | input | NUM_IN | Asynchronous input pins |
| regSel | input | 2 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data of the addressed register (combinational) |
| irqOut | output | 1 | Parent interrupt line |

## Verification
The hardest situation to reach from the ports is an acknowledge that lands in the exact cycle in which an edge event sits at the input of the pending flag. This happens three clock edges after the pin change, once the two synchronizer stages and the previous-level stage have been counted. The directed stimulus toggles a pin and issues the write-1-to-clear two steps later, so the two coincide. The bench also latches edges under code 0 and code 3 and only then selects them, which exposes hidden flags. A long pseudo-random phase mixes pin toggles, trigger writes and acknowledges against the cycle-level model.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam logic [1:0] ADDR_LEVEL = 2'd0;
  localparam logic [1:0] ADDR_CFG   = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  localparam logic [1:0] TRIG_NONE  = 2'd0;
  localparam logic [1:0] TRIG_FALL  = 2'd1;
  localparam logic [1:0] TRIG_RISE  = 2'd2;

  typedef struct packed {
    logic       cfgWr;
    logic       ackWr;
    logic [1:0] rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic [1:0]  regSel,
  input  logic        regWrEn,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.cfgWr = regWrEn && (regSel == ADDR_CFG);
    strobe.ackWr = regWrEn && (regSel == ADDR_STAT);
    strobe.rdSel = regSel;
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_IN-1:0]     gpioIn,
  input  ctrlStrobe_t           strobe,
  input  logic [2*NUM_IN-1:0]   wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqOut,
  output logic [NUM_IN-1:0]     riseEvt,
  output logic [NUM_IN-1:0]     fallEvt,
  output logic [NUM_IN-1:0]     risePend,
  output logic [NUM_IN-1:0]     fallPend,
  output logic [2*NUM_IN-1:0]   cfgWord,
  output logic [NUM_IN-1:0]     statusVec
);
  localparam int CFG_W = 2 * NUM_IN;

  logic [NUM_IN-1:0] syncA, syncB, prevLvl, ackMask;

  // two-stage synchronizer followed by previous-level register
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= gpioIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  assign riseEvt = syncB & ~prevLvl;
  assign fallEvt = ~syncB & prevLvl;
  assign ackMask = strobe.ackWr ? wrData[NUM_IN-1:0] : '0;

  // pending flags: events beat a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      risePend <= '0;
      fallPend <= '0;
    end else begin
      risePend <= (risePend & ~ackMask) | riseEvt;
      fallPend <= (fallPend & ~ackMask) | fallEvt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cfgWord <= '0;
    else if (strobe.cfgWr) cfgWord <= wrData[CFG_W-1:0];
  end

  for (genvar n = 0; n < NUM_IN; n++) begin : g_status
    logic [1:0] trig;
    assign trig = cfgWord[2*n +: 2];
    always_comb begin
      unique case (trig)
        TRIG_FALL: statusVec[n] = fallPend[n];
        TRIG_RISE: statusVec[n] = risePend[n];
        default:   statusVec[n] = 1'b0;
      endcase
    end
  end

  assign irqOut = |statusVec;

  always_comb begin
    unique case (strobe.rdSel)
      ADDR_LEVEL: rdData = DATA_W'(syncB);
      ADDR_CFG:   rdData = DATA_W'(cfgWord);
      ADDR_STAT:  rdData = DATA_W'(statusVec);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] gpioIn,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int CFG_W = 2 * NUM_IN;

  ctrlStrobe_t        strobe;
  logic [NUM_IN-1:0]  riseEvt, fallEvt, risePend, fallPend, statusVec;
  logic [CFG_W-1:0]   cfgWord;

  gpio_edge_ctrl i_ctrl (
    .regSel (regSel),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  gpio_edge_dp #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .gpioIn   (gpioIn),
    .strobe   (strobe),
    .wrData   (regWrData[CFG_W-1:0]),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .riseEvt  (riseEvt),
    .fallEvt  (fallEvt),
    .risePend (risePend),
    .fallPend (fallPend),
    .cfgWord  (cfgWord),
    .statusVec(statusVec)
  );
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          regSel,
  input logic                regWrEn,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic                irqOut,
  input logic [NUM_IN-1:0]   riseEvt,
  input logic [NUM_IN-1:0]   fallEvt,
  input logic [NUM_IN-1:0]   risePend,
  input logic [NUM_IN-1:0]   fallPend,
  input logic [2*NUM_IN-1:0] cfgWord
);
  logic ackWr;
  assign ackWr = regWrEn && (regSel == ADDR_STAT);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irqOut && risePend == '0 && fallPend == '0 && cfgWord == '0));

  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regSel == ADDR_CFG) |=> (cfgWord == $past(regWrData[2*NUM_IN-1:0])));

  assert_irq_vs_status_R6: assert property (@(posedge clk) disable iff (rst)
    (regSel == ADDR_STAT) |-> (irqOut == (|regRdData[NUM_IN-1:0])));

  for (genvar n = 0; n < NUM_IN; n++) begin : g_chk
    assert_rise_latched_R3: assert property (@(posedge clk) disable iff (rst)
      riseEvt[n] |=> risePend[n]);
    assert_fall_latched_R3: assert property (@(posedge clk) disable iff (rst)
      fallEvt[n] |=> fallPend[n]);
    assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      !(riseEvt[n] && fallEvt[n]));
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (ackWr && regWrData[n] && !riseEvt[n] && !fallEvt[n]) |=> (!risePend[n] && !fallPend[n]));
    assert_hold_without_ack_R7: assert property (@(posedge clk) disable iff (rst)
      (risePend[n] && !(ackWr && regWrData[n])) |=> risePend[n]);
  end
endmodule

bind gpio_edge_irq gpio_edge_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .regSel(regSel), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
  .riseEvt(riseEvt), .fallEvt(fallEvt), .risePend(risePend),
  .fallPend(fallPend), .cfgWord(cfgWord)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int PERIOD = 10;
  localparam int N = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]  gpioIn = '0;
  logic [1:0]    regSel = '0;
  logic          regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic          irqOut;

  int compared = 0;
  int mismatched = 0;

  // behavioural reference state
  bit mS1[N], mS2[N], mPv[N], mRise[N], mFall[N];
  int mCfg = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_edge_irq #(.NUM_IN(N), .DATA_W(DW)) i_gpio_edge_irq (
    .clk(clk), .rst(rst), .gpioIn(gpioIn), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic int statusOf();
    int s = 0;
    for (int i = 0; i < N; i++) begin
      int t = (mCfg >> (2*i)) & 3;
      if ((t == 1 && mFall[i]) || (t == 2 && mRise[i])) s |= (1 << i);
    end
    return s;
  endfunction

  function automatic int expRead(int sel);
    int v = 0;
    case (sel)
      0: for (int i = 0; i < N; i++) if (mS2[i]) v |= (1 << i);
      1: v = mCfg;
      2: v = statusOf();
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic compare(string tag);
    int er = expRead(int'(regSel));
    bit ei = (statusOf() != 0);
    compared++;
    if (int'(regRdData) != er || irqOut !== ei) begin
      mismatched++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", tag, regRdData, irqOut, er[DW-1:0], ei);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mS1[i] = 0; mS2[i] = 0; mPv[i] = 0; mRise[i] = 0; mFall[i] = 0;
    end
    mCfg = 0;
  endtask

  task automatic step(input logic [N-1:0] g, input int sel, input bit we, input int wd, input string tag);
    bit nS1[N], nS2[N], nPv[N], nRise[N], nFall[N];
    int nCfg = mCfg;
    gpioIn = g; regSel = sel[1:0]; regWrEn = we; regWrData = wd[DW-1:0];
    for (int i = 0; i < N; i++) begin
      bit ack = we && sel == 2 && wd[i];
      bit r = mS2[i] && !mPv[i];
      bit f = !mS2[i] && mPv[i];
      nS1[i] = g[i]; nS2[i] = mS1[i]; nPv[i] = mS2[i];
      nRise[i] = (mRise[i] && !ack) || r;
      nFall[i] = (mFall[i] && !ack) || f;
    end
    if (we && sel == 1) nCfg = wd & ((1 << (2*N)) - 1);
    @(posedge clk);
    mS1 = nS1; mS2 = nS2; mPv = nPv; mRise = nRise; mFall = nFall; mCfg = nCfg;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [N-1:0] g;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at every address, R10 address 3 zero
    for (int s = 0; s < 4; s++) begin
      regSel = s[1:0];
      #1 compare(s == 3 ? "R10" : "R1");
    end

    // R2: level follows after two edges; write to address 0 ignored
    step(4'b0101, 0, 1, 8'hFF, "R2");
    step(4'b0101, 0, 0, 0, "R2");
    step(4'b0101, 0, 0, 0, "R2");
    step(4'b0101, 1, 0, 0, "R2");
    // R3: edges latched while all triggers are 0, status hidden
    step(4'b0101, 2, 0, 0, "R3");
    // R4: trigger fields read/write, R9 hidden rising flags appear
    step(4'b0101, 1, 1, 8'b10_10_10_10, "R4");
    step(4'b0101, 2, 0, 0, "R9");
    // R7: acknowledge input 0 only
    step(4'b0101, 2, 1, 8'h01, "R7");
    step(4'b0101, 2, 0, 0, "R7");
    // falling edges on inputs 0 and 2 with code 3 on input 0 (R5)
    step(4'b0101, 1, 1, 8'b10_01_10_11, "R5");
    step(4'b0000, 2, 0, 0, "R5");
    step(4'b0000, 2, 0, 0, "R5");
    step(4'b0000, 2, 0, 0, "R5");
    step(4'b0000, 2, 0, 0, "R6");
    // R9: reveal falling flag of input 0 hidden under code 3
    step(4'b0000, 1, 1, 8'b10_01_10_01, "R9");
    step(4'b0000, 2, 0, 0, "R9");
    // R7: clear everything, both flags per input regardless of trigger
    step(4'b0000, 2, 1, 8'h0F, "R7");
    step(4'b0000, 1, 1, 8'b01_01_01_01, "R7");
    step(4'b0000, 2, 0, 0, "R7");
    step(4'b0000, 1, 1, 8'b10_10_10_10, "R7");
    step(4'b0000, 2, 0, 0, "R7");

    // R8: edge event meets acknowledge in the same cycle
    step(4'b0010, 2, 0, 0, "R8");
    step(4'b0010, 2, 0, 0, "R8");
    step(4'b0010, 2, 1, 8'h02, "R8");
    step(4'b0010, 2, 0, 0, "R8");
    step(4'b0010, 2, 1, 8'h02, "R8");
    step(4'b0010, 2, 0, 0, "R8");

    // mixed pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      int op = int'($urandom_range(0, 9));
      g = gpioIn;
      if ($urandom_range(0, 3) == 0) g = g ^ N'($urandom_range(1, (1 << N) - 1));
      if (op == 0)      step(g, 1, 1, int'($urandom_range(0, 255)), "R4");
      else if (op <= 2) step(g, 2, 1, int'($urandom_range(0, 15)), "R7");
      else if (op == 3) step(g, 3, 1, int'($urandom_range(0, 255)), "R10");
      else if (op == 4) step(g, 0, 0, 0, "R2");
      else              step(g, 2, 0, 0, "R6");
    end

    // R1: reset mid-run clears state
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    gpioIn = '0;
    modelReset();
    for (int s = 0; s < 4; s++) begin
      regSel = s[1:0];
      #1 compare("R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule